// File: doc/BRIEF.md
# Region-Aware Word Address Pointer

This block keeps the single word address pointer of a small byte-addressed serial memory. The same pointer serves the main storage array and a separate 16-byte identification area. The bus front end loads it with a received word address, then advances it once for each byte moved. The way it advances depends on what the transfer is doing. Writes stay inside an 8-byte page. Array reads run across the whole array. Identification-area reads cycle through its 16 bytes.

The pointer is never cleared between transactions. A read that sends no word address therefore continues from the byte after the last one touched. An identification-area access that follows array traffic, with no reload in between, starts from whatever the low pointer bits hold at that moment. The array may be 256 bytes, with an 8-bit array address, or 128 bytes, with a 7-bit array address. In the 128-byte case the top pointer bit takes no part in array addressing or array wrap.

Top module: `ptr_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `arr_addr` and `sn_idx` are zero.
- R2: With `load_en` high and `step_en` low at a clock edge, the pointer takes `word_addr` at that edge. `arr_addr` then shows its low ARRAY_AW bits and `sn_idx` its low 4 bits.
- R3: With both `load_en` and `step_en` low, the pointer keeps its value at every edge, across any number of idle cycles.
- R4: A step with `op_write`=1 and `sn_sel`=0 adds one to pointer bits [2:0] modulo 8 and leaves all higher bits unchanged. After address 8'h3F comes 8'h38, and nine steps from 8'h3C end at 8'h3D.
- R5: A step with `op_write`=0 and `sn_sel`=0 adds one to the low ARRAY_AW bits modulo 2^ARRAY_AW. After 8'hFF comes 8'h00.
- R6: A step with `sn_sel`=1 adds one to bits [3:0] modulo 16 and leaves the higher bits unchanged. A load of 8'h80 gives `sn_idx`=0, and index 15 is followed by index 0.
- R7: The pointer is shared by both regions. After array steps with no reload, `sn_idx` equals the low 4 bits of the leftover pointer, and an identification-area step continues from that value.
- R8: With `load_en` and `step_en` both high at the same edge, the result is `word_addr` advanced once by the rule that `op_write` and `sn_sel` select.
- R9: When `sn_sel`=1, the 16-byte wrap applies whatever the value of `op_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Load the pointer from `word_addr` |
| word_addr | input | WORD_W (8) | Received word address |
| step_en | input | 1 | Advance the pointer by one byte |
| op_write | input | 1 | 1 = write transfer (page wrap), 0 = read transfer (array wrap) |
| sn_sel | input | 1 | 1 = identification area selected (16-byte wrap) |
| arr_addr | output | ARRAY_AW (8) | Array byte address |
| sn_idx | output | SN_W (4) | Identification-area byte index |

## Verification
The load and the step can land on the same clock edge. When they do, the block must advance the freshly loaded address rather than the old pointer. The bench provokes this by asserting `load_en` and `step_en` together under each of the three wrap modes. It includes addresses at the page, array and 16-byte boundaries, such as 8'h3F, 8'hFF and 8'h8F. A behavioural model applies the same load-then-advance order, and the bench compares both outputs with that model on every clock.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [1:0] {
    WRAP_PAGE   = 2'd0,
    WRAP_ARRAY  = 2'd1,
    WRAP_SERIAL = 2'd2
  } wrap_mode_e;
endpackage

// File: rtl/ptr_mode_sel.sv
module ptr_mode_sel
  import ptr_pkg::*;
(
  input  logic       op_write,
  input  logic       sn_sel,
  output wrap_mode_e mode
);
  // The identification area takes precedence over the transfer direction.
  always_comb begin
    if (sn_sel)        mode = WRAP_SERIAL;
    else if (op_write) mode = WRAP_PAGE;
    else               mode = WRAP_ARRAY;
  end
endmodule

// File: rtl/ptr_wrap_inc.sv
module ptr_wrap_inc
  import ptr_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int ARRAY_AW = 8,
  parameter int PAGE_W   = 3,
  parameter int SN_W     = 4
) (
  input  logic [WORD_W-1:0] cur,
  input  wrap_mode_e        mode,
  output logic [WORD_W-1:0] nxt
);
  logic [WORD_W-1:0] page_mask;
  logic [WORD_W-1:0] array_mask;
  logic [WORD_W-1:0] sn_mask;
  logic [WORD_W-1:0] sel_mask;
  logic [WORD_W-1:0] plus_one;

  // Each mask marks the bits that belong to the counting field of one mode.
  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    assign page_mask[i]  = (i < PAGE_W);
    assign array_mask[i] = (i < ARRAY_AW);
    assign sn_mask[i]    = (i < SN_W);
  end

  always_comb begin
    unique case (mode)
      WRAP_PAGE:   sel_mask = page_mask;
      WRAP_SERIAL: sel_mask = sn_mask;
      default:     sel_mask = array_mask;
    endcase
  end

  // The carry leaving the masked field is thrown away, so the field wraps to zero.
  assign plus_one = cur + {{(WORD_W-1){1'b0}}, 1'b1};
  assign nxt      = (cur & ~sel_mask) | (plus_one & sel_mask);
endmodule

// File: rtl/ptr_core.sv
module ptr_core
  import ptr_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int ARRAY_AW = 8,
  parameter int PAGE_W   = 3,
  parameter int SN_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [WORD_W-1:0]   word_addr,
  input  logic                step_en,
  input  logic                op_write,
  input  logic                sn_sel,
  output logic [ARRAY_AW-1:0] arr_addr,
  output logic [SN_W-1:0]     sn_idx
);
  wrap_mode_e        mode;
  logic [WORD_W-1:0] ptr_q;
  logic [WORD_W-1:0] ptr_d;
  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] advanced;
  logic              upd_en;

  ptr_mode_sel u_mode (
    .op_write (op_write),
    .sn_sel   (sn_sel),
    .mode     (mode)
  );

  ptr_wrap_inc #(
    .WORD_W   (WORD_W),
    .ARRAY_AW (ARRAY_AW),
    .PAGE_W   (PAGE_W),
    .SN_W     (SN_W)
  ) u_inc (
    .cur  (base),
    .mode (mode),
    .nxt  (advanced)
  );

  // Next state: the load is applied first, then the step advances the result.
  always_comb begin
    base   = load_en ? word_addr : ptr_q;
    ptr_d  = step_en ? advanced : base;
    upd_en = load_en | step_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (upd_en) ptr_q <= ptr_d;
  end

  assign arr_addr = ptr_q[ARRAY_AW-1:0];
  assign sn_idx   = ptr_q[SN_W-1:0];
endmodule

// File: rtl/ptr_core_chk.sv
module ptr_core_chk #(
  parameter int WORD_W   = 8,
  parameter int ARRAY_AW = 8,
  parameter int PAGE_W   = 3,
  parameter int SN_W     = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                load_en,
  input logic [WORD_W-1:0]   word_addr,
  input logic                step_en,
  input logic                op_write,
  input logic                sn_sel,
  input logic [ARRAY_AW-1:0] arr_addr,
  input logic [SN_W-1:0]     sn_idx
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (arr_addr == '0 && sn_idx == '0);
    end
  end

  assert_first_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (arr_addr == '0 && sn_idx == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !step_en) |=> arr_addr == $past(word_addr[ARRAY_AW-1:0]));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> ($stable(arr_addr) && $stable(sn_idx)));

  assert_page_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && op_write && !sn_sel) |=>
      (arr_addr[ARRAY_AW-1:PAGE_W] == $past(arr_addr[ARRAY_AW-1:PAGE_W]) &&
       arr_addr[PAGE_W-1:0] == PAGE_W'($past(arr_addr[PAGE_W-1:0]) + 1'b1)));

  assert_array_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !op_write && !sn_sel) |=>
      arr_addr == ARRAY_AW'($past(arr_addr) + 1'b1));

  assert_serial_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && sn_sel) |=>
      (sn_idx == SN_W'($past(sn_idx) + 1'b1) &&
       arr_addr[ARRAY_AW-1:SN_W] == $past(arr_addr[ARRAY_AW-1:SN_W])));

  assert_load_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && load_en && !op_write && !sn_sel) |=>
      arr_addr == ARRAY_AW'($past(word_addr[ARRAY_AW-1:0]) + 1'b1));
endmodule

bind ptr_core ptr_core_chk #(
  .WORD_W   (WORD_W),
  .ARRAY_AW (ARRAY_AW),
  .PAGE_W   (PAGE_W),
  .SN_W     (SN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_en   (load_en),
  .word_addr (word_addr),
  .step_en   (step_en),
  .op_write  (op_write),
  .sn_sel    (sn_sel),
  .arr_addr  (arr_addr),
  .sn_idx    (sn_idx)
);

// File: tb/sim_ptr_core.sv
module sim_ptr_core;
  logic       clk;
  logic       rst_n;
  logic       load_en;
  logic [7:0] word_addr;
  logic       step_en;
  logic       op_write;
  logic       sn_sel;
  logic [7:0] arr_addr;
  logic [3:0] sn_idx;

  int n_chk;
  int n_bad;
  int model;
  bit done;

  ptr_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .word_addr (word_addr),
    .step_en   (step_en),
    .op_write  (op_write),
    .sn_sel    (sn_sel),
    .arr_addr  (arr_addr),
    .sn_idx    (sn_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag);
    n_chk++;
    if (arr_addr !== model[7:0] || sn_idx !== model[3:0]) begin
      n_bad++;
      $display("FAIL %s: arr_addr=%02h sn_idx=%0h expected arr_addr=%02h sn_idx=%0h",
               tag, arr_addr, sn_idx, model[7:0], model[3:0]);
    end
  endtask

  // Inputs are driven after a falling edge, the model advances at the rising
  // edge, and the outputs are compared at the following falling edge.
  task automatic cyc(input bit ld, input int a, input bit st,
                     input bit wr, input bit sn, input string tag);
    load_en   = ld;
    word_addr = a[7:0];
    step_en   = st;
    op_write  = wr;
    sn_sel    = sn;
    @(posedge clk);
    if (ld) model = a & 255;
    if (st) begin
      if (sn)      model = (model & 8'hF0) | ((model + 1) & 4'hF);
      else if (wr) model = (model & 8'hF8) | ((model + 1) & 3'h7);
      else         model = (model + 1) & 255;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; model = 0; done = 0;
    rst_n = 1'b0; load_en = 0; word_addr = 8'hA5; step_en = 0; op_write = 0; sn_sel = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, "R1 after release");
    // R2 plain load, then R3 hold over idle cycles
    cyc(1, 8'h3C, 0, 0, 0, "R2 load 3C");
    for (int i = 0; i < 4; i++) cyc(0, 8'hFF, 0, 1, 1, "R3 idle hold");
    // R4 page write wrap; nine steps from 3C pass 3F then 38 and end at 3D
    for (int i = 0; i < 9; i++) cyc(0, 0, 1, 1, 0, "R4 page write step");
    cyc(1, 8'h3F, 1, 1, 0, "R8 load+step page boundary");
    // R5 array read wrap across FF
    cyc(1, 8'hFD, 0, 0, 0, "R2 load FD");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0, "R5 array read step");
    // R6 identification area from 80h through wrap
    cyc(1, 8'h80, 0, 0, 1, "R6 load 80");
    for (int i = 0; i < 18; i++) cyc(0, 0, 1, 0, 1, "R6 serial step");
    // R7 leftover pointer carried into identification area
    cyc(1, 8'h1B, 0, 0, 0, "R2 load 1B");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, "R5 array step before R7");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 1, "R7 serial continues leftover");
    // R9 serial wrap wins over write direction
    cyc(1, 8'h8E, 0, 1, 1, "R2 load 8E");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 1, "R9 serial over write");
    // R8 simultaneous load and step in each mode
    cyc(1, 8'hFF, 1, 0, 0, "R8 load+step array FF");
    cyc(1, 8'h8F, 1, 0, 1, "R8 load+step serial 8F");
    cyc(1, 8'h47, 1, 1, 0, "R8 load+step page 47");
    // mixed traffic
    for (int i = 0; i < 300; i++)
      cyc(($urandom % 7) == 0, $urandom % 256, ($urandom % 3) != 0,
          $urandom % 2, ($urandom % 4) == 0, "R8 mixed traffic");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule